// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps a ring of receive buffer descriptors in a small register-based descriptor store and hands them to software one frame at a time. Each descriptor carries a status word, a received-length word and a buffer address. A receive datapath outside the block reports each finished frame as a one-cycle pulse with its length (the 4-byte CRC included) and an error flag. The engine then fills the current descriptor, clears its empty bit so that software owns it, and moves on. The ring size is set by software: a wrap bit in any descriptor sends the engine back to the base descriptor once that descriptor has been used.

If a frame finishes while the current descriptor is still owned by software, the engine raises a sticky busy event and halts. While halted it drops every arriving frame. Software clears the event by writing 1 to it, gives descriptors back by setting their empty bits, and resumes the engine with a clear-halt command. All descriptor words and control registers sit behind one word-addressed host port with combinational reads.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset the control, base, event, halt-status and current-index registers all read 0. Every descriptor word reads 0, so no descriptor is empty.
- R2: While enabled and not halted, a frame pulse that finds the current descriptor empty (status bit 15 set) writes `fd_len` into that descriptor's length word. It also rewrites the status word with bit 15 cleared, bit 0 equal to `fd_err` and every other bit cleared except the wrap bit.
- R3: Writing the status back leaves the wrap bit (status bit 13) as it was, and the buffer address word of the descriptor is never changed by the engine.
- R4: After a descriptor without the wrap bit is used, the current index moves to the next descriptor. After a descriptor with the wrap bit is used, it returns to the base register value.
- R5: Moving on from the last physical descriptor (index NUM_DESC-1) without a wrap bit goes to index 0.
- R6: A frame pulse that finds the current descriptor not empty sets the busy event (event register bit 0) and the halt flag (halt-status register bit 0). It leaves that descriptor and the current index unchanged.
- R7: While halted, frame pulses are dropped: no descriptor word and no index changes.
- R8: Writing 1 to event bit 0 clears the busy event. Writing 0 leaves it set.
- R9: Writing 1 to halt-status bit 0 clears the halt, and the next frame is stored at the index where the engine stopped.
- R10: While the enable bit (control bit 0) is 0, frame pulses change neither descriptors, nor the index, nor the event flags.
- R11: Setting the enable bit from 0 to 1 loads the current index from the base register.
- R12: Host address map: address MSB 0 selects descriptor word `addr[1:0]` (0 status, 1 length, 2 buffer address, 3 reads 0) of descriptor `addr[MSB-1:2]`. Address MSB 1 selects register `addr[2:0]`: 0 control, 1 base, 2 event, 3 halt status, 4 current index (read only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_valid | input | 1 | One-cycle pulse: a frame has finished |
| fd_len | input | LEN_W | Frame length in bytes, CRC included |
| fd_err | input | 1 | Frame finished with an error |
| host_addr | input | IDX_W+3 | Host word address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for `host_addr`, combinational |

## Verification
The bench builds the engine with four descriptors and a 12-bit length field, which makes every pairing of base index and wrap position small enough to sweep in full. Each of the ten pairings runs a complete lap of the ring, then the halt on the first reused descriptor, the dropped frame while halted, the busy-event clear and the resume. A separate run with no wrap bits crosses the physical end of the store, and a disabled run confirms that frames are ignored.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   // Descriptor status word layout
   localparam int STAT_W    = 16;
   localparam int BIT_EMPTY = 15;
   localparam int BIT_WRAP  = 13;
   localparam int BIT_ERR   = 0;

   // Word select inside one descriptor slot
   typedef enum logic [1:0] {
      FLD_STATUS = 2'd0,
      FLD_LENGTH = 2'd1,
      FLD_BUFPTR = 2'd2,
      FLD_SPARE  = 2'd3
   } fld_e;

   // Register select inside the register region
   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_BASE  = 3'd1,
      REG_EVENT = 3'd2,
      REG_RSTAT = 3'd3,
      REG_CUR   = 3'd4
   } reg_sel_e;

   // Status written back when a descriptor is handed to software
   function automatic logic [STAT_W-1:0] released_status(input logic [STAT_W-1:0] old_st,
                                                          input logic             bad);
      logic [STAT_W-1:0] s;
      s           = '0;
      s[BIT_WRAP] = old_st[BIT_WRAP];
      s[BIT_ERR]  = bad;
      return s;
   endfunction

endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
   import rxr_pkg::*;
#(
   parameter int NUM_DESC = 8,
   parameter int IDX_W    = 3,
   parameter int LEN_W    = 16,
   parameter int PTR_W    = 32,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_we,
   input  logic [IDX_W-1:0]  h_idx,
   input  logic [1:0]        h_fld,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   input  logic              e_we,
   input  logic [IDX_W-1:0]  e_idx,
   input  logic [STAT_W-1:0] e_status,
   input  logic [LEN_W-1:0]  e_len,
   output logic [STAT_W-1:0] e_cur_status
);

   logic [STAT_W-1:0] st_all [NUM_DESC];
   logic [LEN_W-1:0]  ln_all [NUM_DESC];
   logic [PTR_W-1:0]  bp_all [NUM_DESC];

   for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
      logic [STAT_W-1:0] st_q;
      logic [LEN_W-1:0]  ln_q;
      logic [PTR_W-1:0]  bp_q;
      logic              e_hit, h_hit;

      assign e_hit = e_we && (e_idx == IDX_W'(i));
      assign h_hit = h_we && (h_idx == IDX_W'(i));

      // engine write wins over a host write to the same slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= '0;
            ln_q <= '0;
         end else if (e_hit) begin
            st_q <= e_status;
            ln_q <= e_len;
         end else if (h_hit) begin
            if (h_fld == FLD_STATUS) st_q <= h_wdata[STAT_W-1:0];
            if (h_fld == FLD_LENGTH) ln_q <= h_wdata[LEN_W-1:0];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             bp_q <= '0;
         else if (h_hit && h_fld == FLD_BUFPTR)  bp_q <= h_wdata[PTR_W-1:0];
      end

      assign st_all[i] = st_q;
      assign ln_all[i] = ln_q;
      assign bp_all[i] = bp_q;
   end

   always_comb begin
      h_rdata = '0;
      for (int i = 0; i < NUM_DESC; i++) begin
         if (h_idx == IDX_W'(i)) begin
            case (h_fld)
               FLD_STATUS: h_rdata = DATA_W'(st_all[i]);
               FLD_LENGTH: h_rdata = DATA_W'(ln_all[i]);
               FLD_BUFPTR: h_rdata = DATA_W'(bp_all[i]);
               default:    h_rdata = '0;
            endcase
         end
      end
   end

   always_comb begin
      e_cur_status = '0;
      for (int i = 0; i < NUM_DESC; i++) begin
         if (e_idx == IDX_W'(i)) e_cur_status = st_all[i];
      end
   end

endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl #(
   parameter int NUM_DESC = 8,
   parameter int IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic             start,
   input  logic [IDX_W-1:0] base_idx,
   input  logic             fd_valid,
   input  logic             cur_empty,
   input  logic             cur_wrap,
   input  logic             busy_w1c,
   input  logic             halt_clr,
   output logic [IDX_W-1:0] cur_idx,
   output logic             halted,
   output logic             busy,
   output logic             accept
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);
   localparam bit               IS_POW2  = ((NUM_DESC & (NUM_DESC - 1)) == 0);

   logic [IDX_W-1:0] cur_q, seq_next, nxt_idx;
   logic             halt_q, busy_q, stall;

   // Sequential successor: a power-of-two store rolls over by itself
   if (IS_POW2) begin : g_roll_free
      assign seq_next = cur_q + 1'b1;
   end else begin : g_roll_cmp
      assign seq_next = (cur_q == LAST_IDX) ? '0 : cur_q + 1'b1;
   end

   assign nxt_idx = cur_wrap ? base_idx : seq_next;
   assign accept  = fd_valid && rx_en && !halt_q &&  cur_empty;
   assign stall   = fd_valid && rx_en && !halt_q && !cur_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_q <= '0;
      else if (start)  cur_q <= base_idx;
      else if (accept) cur_q <= nxt_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        halt_q <= 1'b0;
      else if (stall)    halt_q <= 1'b1;
      else if (halt_clr) halt_q <= 1'b0;
   end

   // a new busy condition wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_q <= 1'b0;
      else if (stall)    busy_q <= 1'b1;
      else if (busy_w1c) busy_q <= 1'b0;
   end

   assign cur_idx = cur_q;
   assign halted  = halt_q;
   assign busy    = busy_q;

endmodule

// File: rtl/rxr_host_regs.sv
module rxr_host_regs
   import rxr_pkg::*;
#(
   parameter int NUM_DESC = 8,
   parameter int IDX_W    = 3,
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [DATA_W-1:0] desc_rdata,
   input  logic [IDX_W-1:0]  cur_idx,
   input  logic              halted,
   input  logic              busy,
   output logic              rx_en,
   output logic [IDX_W-1:0]  base_idx,
   output logic              start,
   output logic              busy_w1c,
   output logic              halt_clr,
   output logic              desc_we,
   output logic [IDX_W-1:0]  desc_idx,
   output logic [1:0]        desc_fld
);

   logic             reg_space;
   logic [2:0]       sel;
   logic             wr_ctrl, wr_base, wr_evt, wr_rstat, base_ok;
   logic             en_q;
   logic [IDX_W-1:0] base_q;

   assign reg_space = host_addr[ADDR_W-1];
   assign sel       = host_addr[2:0];
   assign desc_idx  = host_addr[ADDR_W-2:2];
   assign desc_fld  = host_addr[1:0];
   assign desc_we   = host_we && !reg_space;

   assign wr_ctrl  = host_we && reg_space && (sel == REG_CTRL);
   assign wr_base  = host_we && reg_space && (sel == REG_BASE);
   assign wr_evt   = host_we && reg_space && (sel == REG_EVENT);
   assign wr_rstat = host_we && reg_space && (sel == REG_RSTAT);
   assign base_ok  = (host_wdata < DATA_W'(NUM_DESC));

   assign start    = wr_ctrl && host_wdata[0] && !en_q;
   assign busy_w1c = wr_evt && host_wdata[0];
   assign halt_clr = wr_rstat && host_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (wr_ctrl) en_q <= host_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  base_q <= '0;
      else if (wr_base && base_ok) base_q <= host_wdata[IDX_W-1:0];
   end

   always_comb begin
      host_rdata = '0;
      if (!reg_space) begin
         host_rdata = desc_rdata;
      end else begin
         case (sel)
            REG_CTRL:  host_rdata = DATA_W'(en_q);
            REG_BASE:  host_rdata = DATA_W'(base_q);
            REG_EVENT: host_rdata = DATA_W'(busy);
            REG_RSTAT: host_rdata = DATA_W'(halted);
            REG_CUR:   host_rdata = DATA_W'(cur_idx);
            default:   host_rdata = '0;
         endcase
      end
   end

   assign rx_en    = en_q;
   assign base_idx = base_q;

endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
   import rxr_pkg::*;
#(
   parameter int  NUM_DESC = 8,
   parameter int  LEN_W    = 16,
   parameter int  PTR_W    = 32,
   parameter int  DATA_W   = 32,
   localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
   localparam int ADDR_W   = IDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fd_valid,
   input  logic [LEN_W-1:0]  fd_len,
   input  logic              fd_err,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_we,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);

   initial begin
      if (NUM_DESC < 2)      $fatal(1, "NUM_DESC must be at least 2");
      if (DATA_W < STAT_W)   $fatal(1, "DATA_W must hold a status word");
      if (LEN_W > DATA_W)    $fatal(1, "LEN_W must not exceed DATA_W");
      if (PTR_W > DATA_W)    $fatal(1, "PTR_W must not exceed DATA_W");
      if (DATA_W < IDX_W)    $fatal(1, "DATA_W must hold an index");
   end

   logic              rx_en, start, busy_w1c, halt_clr;
   logic              desc_we, accept, halted, busy;
   logic [IDX_W-1:0]  base_idx, cur_idx, desc_idx;
   logic [1:0]        desc_fld;
   logic [DATA_W-1:0] desc_rdata;
   logic [STAT_W-1:0] cur_status, new_status;
   logic              cur_empty, cur_wrap;

   assign cur_empty  = cur_status[BIT_EMPTY];
   assign cur_wrap   = cur_status[BIT_WRAP];
   assign new_status = released_status(cur_status, fd_err);

   rxr_host_regs #(
      .NUM_DESC (NUM_DESC),
      .IDX_W    (IDX_W),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_addr  (host_addr),
      .host_we    (host_we),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .desc_rdata (desc_rdata),
      .cur_idx    (cur_idx),
      .halted     (halted),
      .busy       (busy),
      .rx_en      (rx_en),
      .base_idx   (base_idx),
      .start      (start),
      .busy_w1c   (busy_w1c),
      .halt_clr   (halt_clr),
      .desc_we    (desc_we),
      .desc_idx   (desc_idx),
      .desc_fld   (desc_fld)
   );

   rxr_ring_ctrl #(
      .NUM_DESC (NUM_DESC),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .start     (start),
      .base_idx  (base_idx),
      .fd_valid  (fd_valid),
      .cur_empty (cur_empty),
      .cur_wrap  (cur_wrap),
      .busy_w1c  (busy_w1c),
      .halt_clr  (halt_clr),
      .cur_idx   (cur_idx),
      .halted    (halted),
      .busy      (busy),
      .accept    (accept)
   );

   rxr_desc_mem #(
      .NUM_DESC (NUM_DESC),
      .IDX_W    (IDX_W),
      .LEN_W    (LEN_W),
      .PTR_W    (PTR_W),
      .DATA_W   (DATA_W)
   ) u_mem (
      .clk          (clk),
      .rst_n        (rst_n),
      .h_we         (desc_we),
      .h_idx        (desc_idx),
      .h_fld        (desc_fld),
      .h_wdata      (host_wdata),
      .h_rdata      (desc_rdata),
      .e_we         (accept),
      .e_idx        (cur_idx),
      .e_status     (new_status),
      .e_len        (fd_len),
      .e_cur_status (cur_status)
   );

endmodule

// File: rtl/rxd_ring_engine_chk.sv
module rxd_ring_engine_chk #(
   parameter int NUM_DESC = 8,
   parameter int IDX_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fd_valid,
   input logic             rx_en,
   input logic             accept,
   input logic             cur_wrap,
   input logic             halted,
   input logic             busy,
   input logic [IDX_W-1:0] base_idx,
   input logic [IDX_W-1:0] cur_idx
);

   logic [IDX_W-1:0] succ_idx;
   assign succ_idx = (cur_idx == IDX_W'(NUM_DESC - 1)) ? '0 : IDX_W'(cur_idx + 1'b1);

   AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cur_idx) < NUM_DESC); // R5

   AST_STEP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !cur_wrap |=> cur_idx == $past(succ_idx)); // R4

   AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && cur_wrap |=> cur_idx == $past(base_idx)); // R4

   AST_HALT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> busy); // R6

   AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      halted && fd_valid |=> $stable(cur_idx) || $rose(rx_en)); // R7

   AST_DISABLED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> $stable(cur_idx) || rx_en); // R10

   AST_DISABLED_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en && !busy |=> !busy); // R10

endmodule

bind rxd_ring_engine rxd_ring_engine_chk #(
   .NUM_DESC (NUM_DESC),
   .IDX_W    (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fd_valid (fd_valid),
   .rx_en    (rx_en),
   .accept   (accept),
   .cur_wrap (cur_wrap),
   .halted   (halted),
   .busy     (busy),
   .base_idx (base_idx),
   .cur_idx  (cur_idx)
);

// File: tb/rxd_ring_engine_test.sv
module rxd_ring_engine_test;

   localparam int ND     = 4;
   localparam int LW     = 12;
   localparam int AW     = 5;
   localparam int DW     = 32;
   localparam logic [31:0] S_EMPTY = 32'h8000;
   localparam logic [31:0] S_WRAP  = 32'h2000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fd_valid = 1'b0;
   logic [LW-1:0] fd_len = '0;
   logic          fd_err = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic          host_we = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   rxd_ring_engine #(.NUM_DESC(ND), .LEN_W(LW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fd_valid   (fd_valid),
      .fd_len     (fd_len),
      .fd_err     (fd_err),
      .host_addr  (host_addr),
      .host_we    (host_we),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         errors++;
         $display("FAIL watchdog (R1..R12 run): actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [AW-1:0] da(input int idx, input int fld);
      return {1'b0, 2'(idx), 2'(fld)};
   endfunction

   function automatic logic [AW-1:0] ra(input int sel);
      return {2'b10, 3'(sel)};
   endfunction

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic frame(input int len, input logic err);
      @(negedge clk);
      fd_valid = 1'b1; fd_len = LW'(len); fd_err = err;
      @(negedge clk);
      fd_valid = 1'b0;
   endtask

   task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic rchk(input string req, input string what, input logic [AW-1:0] a,
                       input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      rd(a, v);
      chk(req, what, v, exp);
   endtask

   initial begin
      logic [DW-1:0] v;
      int            first_len;
      logic          first_err;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R12 reset state
      rchk("R1", "ctrl",  ra(0), 0);
      rchk("R1", "base",  ra(1), 0);
      rchk("R1", "event", ra(2), 0);
      rchk("R1", "rstat", ra(3), 0);
      rchk("R1", "cur",   ra(4), 0);
      for (int i = 0; i < ND; i++) begin
         rchk("R1", "status", da(i, 0), 0);
         rchk("R1", "bufptr", da(i, 2), 0);
      end

      // sweep of base index and wrap position
      for (int b = 0; b < ND; b++) begin
         for (int w = b; w < ND; w++) begin
            wr(ra(0), 0);
            wr(ra(2), 1);
            wr(ra(3), 1);
            for (int i = 0; i < ND; i++) begin
               wr(da(i, 0), S_EMPTY | ((i == w) ? S_WRAP : 0));
               wr(da(i, 1), 0);
               wr(da(i, 2), 32'h1000 * i + 32'h10 * b + w);
            end
            rchk("R12", "spare word", da(w, 3), 0);
            wr(ra(1), b);
            wr(ra(0), 1);
            rchk("R11", "cur after enable", ra(4), b);
            for (int k = 0; k <= w - b; k++) begin
               int   len;
               logic e;
               int   d;
               d   = b + k;
               len = 60 + 7 * k + 3 * b + w;
               e   = 1'((k + w) % 2);
               if (k == 0) begin first_len = len; first_err = e; end
               frame(len, e);
               rchk("R4", "cur after frame", ra(4), (k == w - b) ? b : b + k + 1);
               rchk("R2", "length", da(d, 1), len);
               rchk("R3", "status", da(d, 0), {31'd0, e} | ((d == w) ? S_WRAP : 0));
               rchk("R3", "bufptr", da(d, 2), 32'h1000 * d + 32'h10 * b + w);
            end
            rchk("R6", "event before", ra(2), 0);
            frame(1500, 1'b0);
            rchk("R6", "event", ra(2), 1);
            rchk("R6", "rstat", ra(3), 1);
            rchk("R6", "cur held", ra(4), b);
            rchk("R6", "status held", da(b, 0), {31'd0, first_err} | ((b == w) ? S_WRAP : 0));
            // re-arm the blocking descriptor, still halted
            wr(da(b, 0), S_EMPTY | ((b == w) ? S_WRAP : 0));
            frame(777, 1'b1);
            rchk("R7", "length kept", da(b, 1), first_len);
            rchk("R7", "status kept", da(b, 0), S_EMPTY | ((b == w) ? S_WRAP : 0));
            rchk("R7", "cur kept", ra(4), b);
            wr(ra(2), 0);
            rchk("R8", "event after write 0", ra(2), 1);
            wr(ra(2), 1);
            rchk("R8", "event after write 1", ra(2), 0);
            wr(ra(3), 1);
            rchk("R9", "rstat cleared", ra(3), 0);
            frame(200 + b + w, 1'b0);
            rchk("R9", "length on resume", da(b, 1), 200 + b + w);
            rchk("R9", "cur on resume", ra(4), (b == w) ? b : b + 1);
         end
      end

      // R5 roll-over past the last descriptor with no wrap bits
      wr(ra(0), 0);
      wr(ra(2), 1);
      wr(ra(3), 1);
      for (int i = 0; i < ND; i++) wr(da(i, 0), S_EMPTY);
      wr(ra(1), 2);
      wr(ra(0), 1);
      frame(100, 1'b0);
      rchk("R5", "cur after index 2", ra(4), 3);
      frame(101, 1'b0);
      rchk("R5", "cur after last", ra(4), 0);
      frame(102, 1'b0);
      rchk("R5", "length at 0", da(0, 1), 102);
      rchk("R5", "cur after 0", ra(4), 1);

      // R10 disabled engine ignores frames
      wr(ra(0), 0);
      frame(333, 1'b1);
      rchk("R10", "cur", ra(4), 1);
      rchk("R10", "status", da(1, 0), S_EMPTY);
      rchk("R10", "length", da(1, 1), 0);
      rchk("R10", "event", ra(2), 0);
      rchk("R10", "ctrl", ra(0), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule